// File: doc/BRIEF.md
# Resonant Switch Cycle Timer

This block sets the timing of every switching cycle of a resonant, discontinuous forward power stage. While the primary switch is off, it measures how long the transformer takes to ring. The measurement runs from a rising current-comparator event on the collector-sense input to the following falling event. The next turn-on is then placed at that falling event, which marks the resonance minimum. The on-period that follows lasts three quarters of the measured ring time, which gives a nominal duty near 43%.

Around each turn-on the timer produces several outputs. The base drive gets a strong force-on pulse, followed by a proportional-drive enable. A clamp-enable window opens one clock before turn-on. A blanking window masks the over-current comparator. Two strobes tell the mode manager when to sample the light-load comparator and when an over-current trip came early enough to count as a heavy overload. The mode manager shortens the on-time through a trim input and adds off-time through an extension input. Every time is counted in system clocks.

Top module: `rsct_timer`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every output is low. The first on-period after reset uses a ring period of 35 clocks.
- R2: The ring period is the number of clocks from the clock in which `col_rise` is sampled to the clock in which `col_fall` is sampled. A value below 35 becomes 35. If no fall arrives, the measurement ends after 280 clocks and yields 280. If no rise arrives, the off-period also ends after 280 clocks and yields 280.
- R3: The on-period lasts max(4, floor(3·P/4) − `on_trim`) clocks. P is the ring period measured in the preceding off-period. `on_trim` is sampled in the clock before turn-on.
- R4: After the clock that samples the ending fall event, the switch stays off for `off_ext` further clocks, then for one pre-on clock, and then turns on. `off_ext` is sampled together with the fall.
- R5: `fon_drv` is high for the first min(8, on-length) clocks of the on-period. `prop_drv` is high for the rest of it. Both are low while the switch is off.
- R6: `clamp_en` is high in the clock before turn-on. It stays high for the first 4 clocks of the on-period, or the first 3 when `standby` is high.
- R7: `ocp_blank` is high for the first 4 clocks of the on-period. An `ocp_hit` during those clocks is ignored.
- R8: An `ocp_hit` sampled in on-clock k, with k ≥ 4, ends the on-period: the on-length is k+1.
- R9: `light_smp` pulses once, in on-clock 19 (counting the turn-on clock as 0), but only if the on-period lasts that long.
- R10: `fold_hit` pulses in the clock where an over-current trip is accepted, if that clock's index is below 26.
- R11: A `col_fall` while the timer waits for the rise is ignored. A `col_rise` while a measurement runs is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_rise | input | 1 | Rising collector-current comparator event |
| col_fall | input | 1 | Falling collector-current comparator event |
| ocp_hit | input | 1 | Over-current comparator output |
| standby | input | 1 | Light-load mode; shortens the clamp window |
| on_trim | input | 9 | On-time reduction in clocks |
| off_ext | input | 10 | Extra off-time in clocks |
| sw_on | output | 1 | Primary switch on |
| fon_drv | output | 1 | Force-on base-drive pulse |
| prop_drv | output | 1 | Proportional base-drive enable |
| clamp_en | output | 1 | Collector clamp enable |
| ocp_blank | output | 1 | Over-current blanking window |
| light_smp | output | 1 | Light-load comparator sample strobe |
| fold_hit | output | 1 | Early over-current trip (foldback window) |

## Verification
The checker assumes the comparator events are single-clock pulses and that a rise and a fall never arrive in the same clock. It also assumes `ocp_hit` is released once the switch has gone off. The bench respects all of this: each event is driven for exactly one clock, at the falling edge. The bench raises the over-current flag only during an on-period and drops it in the first off clock. Spurious events are placed only in the phases where R11 requires them to be ignored. The trim and extension inputs change only while the switch is off, well before the clock that samples them.

// File: rtl/rsct_pkg.sv
package rsct_pkg;
   typedef enum logic [2:0] {
      PH_PRE  = 3'd0,
      PH_ON   = 3'd1,
      PH_WAIT = 3'd2,
      PH_MEAS = 3'd3,
      PH_XOFF = 3'd4
   } rsct_phase_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rsct_seq.sv
module rsct_seq
   import rsct_pkg::*;
#(
   parameter int unsigned RES_MAX    = 280,
   parameter int unsigned BLANK_CLKS = 4,
   parameter int unsigned CW         = 9,
   parameter int unsigned XOFF_W     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              col_rise,
   input  logic              col_fall,
   input  logic              ocp_hit,
   input  logic [CW-1:0]     ton_len,
   input  logic [XOFF_W-1:0] off_ext,
   output rsct_phase_e       phase,
   output logic [CW-1:0]     on_cnt,
   output logic              trip_ok,
   output logic              meas_done,
   output logic [CW-1:0]     meas_len
);
   localparam int unsigned KW = max_u(CW, XOFF_W);

   logic [KW-1:0]     cnt;
   logic [XOFF_W-1:0] xoff_q;
   logic              on_last;

   assign on_cnt = cnt[CW-1:0];

   always_comb begin
      trip_ok   = (phase == PH_ON) && ocp_hit && (cnt >= KW'(BLANK_CLKS));
      on_last   = (phase == PH_ON) && (cnt == KW'(ton_len) - KW'(1));
      meas_done = ((phase == PH_WAIT) && !col_rise && (cnt == KW'(RES_MAX))) ||
                  ((phase == PH_MEAS) && (col_fall || (cnt == KW'(RES_MAX))));
      meas_len  = ((phase == PH_MEAS) && col_fall) ? cnt[CW-1:0] : CW'(RES_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_XOFF;
         cnt    <= '0;
         xoff_q <= '0;
      end else begin
         unique case (phase)
            PH_PRE: begin
               phase <= PH_ON;
               cnt   <= '0;
            end
            PH_ON: begin
               if (trip_ok || on_last) begin
                  phase <= PH_WAIT;
                  cnt   <= KW'(1);
               end else begin
                  cnt <= cnt + KW'(1);
               end
            end
            PH_WAIT, PH_MEAS: begin
               if ((phase == PH_WAIT) && col_rise) begin
                  phase <= PH_MEAS;
                  cnt   <= KW'(1);
               end else if (meas_done) begin
                  xoff_q <= off_ext;
                  cnt    <= KW'(1);
                  phase  <= (off_ext == '0) ? PH_PRE : PH_XOFF;
               end else begin
                  cnt <= cnt + KW'(1);
               end
            end
            PH_XOFF: begin
               if (cnt >= KW'(xoff_q)) begin
                  phase <= PH_PRE;
               end else begin
                  cnt <= cnt + KW'(1);
               end
            end
            default: phase <= PH_XOFF;
         endcase
      end
   end
endmodule

// File: rtl/rsct_period.sv
module rsct_period #(
   parameter int unsigned RES_MIN = 35,
   parameter int unsigned RES_MAX = 280,
   parameter int unsigned CW      = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          meas_done,
   input  logic [CW-1:0] meas_len,
   output logic [CW-1:0] res_q
);
   logic [CW-1:0] bounded;

   always_comb begin
      if (meas_len < CW'(RES_MIN))      bounded = CW'(RES_MIN);
      else if (meas_len > CW'(RES_MAX)) bounded = CW'(RES_MAX);
      else                              bounded = meas_len;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         res_q <= CW'(RES_MIN);
      else if (meas_done) res_q <= bounded;
   end
endmodule

// File: rtl/rsct_ontime.sv
module rsct_ontime #(
   parameter int unsigned BLANK_CLKS = 4,
   parameter int unsigned CW         = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] res,
   input  logic [CW-1:0] trim,
   output logic [CW-1:0] ton_len
);
   localparam int unsigned SW = CW + 2;

   logic [SW-1:0] scaled;
   logic [SW-1:0] reduced;
   logic [CW-1:0] target;

   always_comb begin
      scaled  = ({2'b00, res} * SW'(3)) >> 2;
      reduced = (scaled > {2'b00, trim}) ? (scaled - {2'b00, trim}) : '0;
      target  = (reduced < SW'(BLANK_CLKS)) ? CW'(BLANK_CLKS) : reduced[CW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ton_len <= CW'(BLANK_CLKS);
      else if (load) ton_len <= target;
   end
endmodule

// File: rtl/rsct_windows.sv
module rsct_windows
   import rsct_pkg::*;
#(
   parameter int unsigned CW         = 9,
   parameter int unsigned FON_CLKS   = 8,
   parameter int unsigned BLANK_CLKS = 4,
   parameter int unsigned CLAMP_NRM  = 4,
   parameter int unsigned CLAMP_SB   = 3,
   parameter int unsigned LL_AT      = 19,
   parameter int unsigned FB_END     = 26
) (
   input  rsct_phase_e   phase,
   input  logic [CW-1:0] on_cnt,
   input  logic          standby,
   input  logic          trip_ok,
   output logic          sw_on,
   output logic          fon_drv,
   output logic          prop_drv,
   output logic          clamp_en,
   output logic          ocp_blank,
   output logic          light_smp,
   output logic          fold_hit
);
   logic          is_on;
   logic [CW-1:0] clamp_len;

   always_comb begin
      is_on     = (phase == PH_ON);
      clamp_len = standby ? CW'(CLAMP_SB) : CW'(CLAMP_NRM);
      sw_on     = is_on;
      clamp_en  = (phase == PH_PRE) || (is_on && (on_cnt < clamp_len));
      ocp_blank = is_on && (on_cnt < CW'(BLANK_CLKS));
      light_smp = is_on && (on_cnt == CW'(LL_AT));
      fold_hit  = trip_ok && (on_cnt < CW'(FB_END));
   end

   generate
      if (FON_CLKS == 0) begin : g_no_fon
         assign fon_drv  = 1'b0;
         assign prop_drv = is_on;
      end else begin : g_fon
         assign fon_drv  = is_on && (on_cnt < CW'(FON_CLKS));
         assign prop_drv = is_on && (on_cnt >= CW'(FON_CLKS));
      end
   endgenerate
endmodule

// File: rtl/rsct_timer.sv
module rsct_timer
   import rsct_pkg::*;
#(
   parameter int unsigned RES_MIN    = 35,
   parameter int unsigned RES_MAX    = 280,
   parameter int unsigned BLANK_CLKS = 4,
   parameter int unsigned FON_CLKS   = 8,
   parameter int unsigned CLAMP_NRM  = 4,
   parameter int unsigned CLAMP_SB   = 3,
   parameter int unsigned LL_AT      = 19,
   parameter int unsigned FB_END     = 26,
   parameter int unsigned XOFF_W     = 10,
   localparam int unsigned CW        = $clog2(RES_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              col_rise,
   input  logic              col_fall,
   input  logic              ocp_hit,
   input  logic              standby,
   input  logic [CW-1:0]     on_trim,
   input  logic [XOFF_W-1:0] off_ext,
   output logic              sw_on,
   output logic              fon_drv,
   output logic              prop_drv,
   output logic              clamp_en,
   output logic              ocp_blank,
   output logic              light_smp,
   output logic              fold_hit
);
   if (RES_MIN < 1 || RES_MIN >= RES_MAX) begin : g_bad_range
      $error("rsct_timer: RES_MIN must be at least 1 and below RES_MAX");
   end
   if (BLANK_CLKS < 1 || BLANK_CLKS > (3 * RES_MIN) / 4) begin : g_bad_blank
      $error("rsct_timer: BLANK_CLKS must fit inside the shortest on-time");
   end
   if (FB_END > RES_MAX || LL_AT > RES_MAX) begin : g_bad_strobe
      $error("rsct_timer: strobe offsets exceed the counter range");
   end
   if (XOFF_W < 1) begin : g_bad_xoff
      $error("rsct_timer: XOFF_W must be positive");
   end

   rsct_phase_e   phase;
   logic [CW-1:0] on_cnt;
   logic          trip_ok;
   logic          meas_done;
   logic [CW-1:0] meas_len;
   logic [CW-1:0] res_q;
   logic [CW-1:0] ton_len;

   rsct_seq #(
      .RES_MAX(RES_MAX), .BLANK_CLKS(BLANK_CLKS), .CW(CW), .XOFF_W(XOFF_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .col_rise(col_rise), .col_fall(col_fall),
      .ocp_hit(ocp_hit), .ton_len(ton_len), .off_ext(off_ext),
      .phase(phase), .on_cnt(on_cnt), .trip_ok(trip_ok),
      .meas_done(meas_done), .meas_len(meas_len)
   );

   rsct_period #(
      .RES_MIN(RES_MIN), .RES_MAX(RES_MAX), .CW(CW)
   ) u_period (
      .clk(clk), .rst_n(rst_n), .meas_done(meas_done),
      .meas_len(meas_len), .res_q(res_q)
   );

   rsct_ontime #(
      .BLANK_CLKS(BLANK_CLKS), .CW(CW)
   ) u_ontime (
      .clk(clk), .rst_n(rst_n), .load(phase == PH_PRE),
      .res(res_q), .trim(on_trim), .ton_len(ton_len)
   );

   rsct_windows #(
      .CW(CW), .FON_CLKS(FON_CLKS), .BLANK_CLKS(BLANK_CLKS),
      .CLAMP_NRM(CLAMP_NRM), .CLAMP_SB(CLAMP_SB),
      .LL_AT(LL_AT), .FB_END(FB_END)
   ) u_win (
      .phase(phase), .on_cnt(on_cnt), .standby(standby), .trip_ok(trip_ok),
      .sw_on(sw_on), .fon_drv(fon_drv), .prop_drv(prop_drv),
      .clamp_en(clamp_en), .ocp_blank(ocp_blank),
      .light_smp(light_smp), .fold_hit(fold_hit)
   );
endmodule

// File: rtl/rsct_timer_chk.sv
module rsct_timer_chk #(
   parameter int unsigned FON_CLKS = 8
) (
   input logic clk,
   input logic rst_n,
   input logic ocp_hit,
   input logic sw_on,
   input logic fon_drv,
   input logic prop_drv,
   input logic clamp_en,
   input logic ocp_blank,
   input logic light_smp,
   input logic fold_hit
);
   // R7
   blank_in_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ocp_blank |-> sw_on);

   // R6
   clamp_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_on) |-> $past(clamp_en));

   // R8
   trip_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_on && ocp_hit && !ocp_blank) |=> !sw_on);

   // R10
   fold_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fold_hit |-> (sw_on && ocp_hit && !ocp_blank));

   // R9
   light_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      light_smp |=> !light_smp);

   // R5
   drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_on |-> (!fon_drv && !prop_drv));

   generate
      if (FON_CLKS > 0) begin : g_fon_order
         // R5
         fon_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(prop_drv) |-> $past(fon_drv));
      end
   endgenerate
endmodule

bind rsct_timer rsct_timer_chk #(.FON_CLKS(FON_CLKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .ocp_hit(ocp_hit), .sw_on(sw_on),
   .fon_drv(fon_drv), .prop_drv(prop_drv), .clamp_en(clamp_en),
   .ocp_blank(ocp_blank), .light_smp(light_smp), .fold_hit(fold_hit)
);

// File: tb/rsct_timer_bench.sv
module rsct_timer_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int    len;
      int    fon;
      int    clamp;
      int    blank;
      int    ll;
      int    fold;
      int    off;
      bit    trip;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       col_rise = 1'b0;
   logic       col_fall = 1'b0;
   logic       ocp_hit = 1'b0;
   logic       standby = 1'b0;
   logic [8:0] on_trim = '0;
   logic [9:0] off_ext = '0;
   logic sw_on, fon_drv, prop_drv, clamp_en, ocp_blank, light_smp, fold_hit;

   int   nchk = 0;
   int   nfail = 0;
   exp_t q[$];
   bit   mon_on = 1'b0;
   bit   stop = 1'b0;
   int   res_prev = 35;
   int   cut_cur = 0;
   int   off_prev = -1;

   rsct_timer u_rsct_timer (
      .clk(clk), .rst_n(rst_n), .col_rise(col_rise), .col_fall(col_fall),
      .ocp_hit(ocp_hit), .standby(standby), .on_trim(on_trim), .off_ext(off_ext),
      .sw_on(sw_on), .fon_drv(fon_drv), .prop_drv(prop_drv), .clamp_en(clamp_en),
      .ocp_blank(ocp_blank), .light_smp(light_smp), .fold_hit(fold_hit)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: measures each on-period and compares with the queued expectation
   int  m_len, m_fon, m_prop, m_clamp, m_blank, m_ll, m_fold, m_off, off_cnt;
   bit  in_on = 1'b0;
   bit  prev_clamp = 1'b0;
   always begin
      @(negedge clk);
      #(CLK_PERIOD / 4);
      if (mon_on && !stop) begin
         if (sw_on) begin
            if (!in_on) begin
               in_on = 1'b1;
               chk("R6 clamp in pre-on clock", int'(prev_clamp), 1);
               m_off = off_cnt;
               m_len = 0; m_fon = 0; m_prop = 0; m_clamp = 0;
               m_blank = 0; m_ll = 0; m_fold = 0;
            end
            m_len++;
            m_fon   += int'(fon_drv);
            m_prop  += int'(prop_drv);
            m_clamp += int'(clamp_en);
            m_blank += int'(ocp_blank);
            m_ll    += int'(light_smp);
            m_fold  += int'(fold_hit);
         end else begin
            if (in_on) begin
               in_on = 1'b0;
               off_cnt = 0;
               if (q.size() == 0) begin
                  chk("R3 unexpected on-period", m_len, 0);
               end else begin
                  exp_t it;
                  it = q.pop_front();
                  chk(it.trip ? {"R8 on-length ", it.tag} : {"R3 on-length ", it.tag},
                      m_len, it.len);
                  chk("R5 force-on clocks", m_fon, it.fon);
                  chk("R5 proportional clocks", m_prop, it.len - it.fon);
                  chk("R6 clamp clocks in on-period", m_clamp, it.clamp);
                  chk("R7 blank clocks", m_blank, it.blank);
                  chk("R9 light-load strobes", m_ll, it.ll);
                  chk("R10 fold strobes", m_fold, it.fold);
                  if (it.off >= 0) chk({"R4 off clocks ", it.tag}, m_off, it.off);
               end
            end
            off_cnt++;
         end
         prev_clamp = clamp_en;
      end
   end

   // driver: one switching cycle, pushes the expectation of its on-period
   task automatic drive_period(input int trip_at, input bit sb, input int rdly,
                               input int fd, input int ext, input int cut_next,
                               input bit spur, input string tag);
      exp_t it;
      int   full, ton, ta, mlen;
      full = (3 * res_prev) / 4;
      ton  = (full > cut_cur) ? full - cut_cur : 0;
      if (ton < 4) ton = 4;
      it.trip = 1'b0;
      it.len  = ton;
      it.fold = 0;
      if (trip_at >= 0) begin
         ta = (trip_at < 4) ? 4 : trip_at;
         if (ta <= ton - 1) begin
            it.trip = 1'b1;
            it.len  = ta + 1;
            it.fold = (ta < 26) ? 1 : 0;
         end
      end
      it.fon   = (it.len < 8) ? it.len : 8;
      it.clamp = (it.len < (sb ? 3 : 4)) ? it.len : (sb ? 3 : 4);
      it.blank = (it.len < 4) ? it.len : 4;
      it.ll    = (it.len > 19) ? 1 : 0;
      it.off   = off_prev;
      it.tag   = tag;
      q.push_back(it);
      standby = sb;
      while (!sw_on) @(negedge clk);
      for (int k = 0; sw_on; k++) begin
         if (trip_at >= 0 && k == trip_at) ocp_hit = 1'b1;
         @(negedge clk);
      end
      ocp_hit = 1'b0;
      off_ext = 10'(ext);
      on_trim = 9'(cut_next);
      if (spur && rdly > 0) col_fall = 1'b1;
      for (int r = 0; r < rdly; r++) begin
         @(negedge clk);
         col_fall = 1'b0;
      end
      col_rise = 1'b1;
      mlen = (fd > 280) ? 280 : fd;
      for (int j = 1; j <= mlen; j++) begin
         @(negedge clk);
         col_rise = 1'b0;
         if (spur && j == 2 && fd > 2) col_rise = 1'b1;
         if (j == fd) col_fall = 1'b1;
      end
      @(negedge clk);
      col_rise = 1'b0;
      col_fall = 1'b0;
      res_prev = (fd > 280) ? 280 : ((fd < 35) ? 35 : fd);
      off_prev = rdly + 1 + mlen + 1 + ext;
      cut_cur  = cut_next;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 outputs in reset",
          int'({sw_on, fon_drv, prop_drv, clamp_en, ocp_blank, light_smp, fold_hit}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      #(CLK_PERIOD / 4);
      chk("R1 outputs after release",
          int'({sw_on, fon_drv, prop_drv, clamp_en, ocp_blank, light_smp, fold_hit}), 0);
      @(negedge clk);
      drive_period(-1, 1'b0, 0, 100, 0, 0, 1'b0, "R1 first period 35");
      drive_period(-1, 1'b1, 3, 200, 2, 10, 1'b1, "period 100 standby");
      drive_period(-1, 1'b0, 0, 20, 0, 0, 1'b0, "R11 spurious events");
      drive_period(-1, 1'b0, 0, 400, 0, 0, 1'b0, "R2 low clamp");
      drive_period(-1, 1'b0, 0, 50, 5, 300, 1'b0, "R2 missing fall");
      drive_period(1, 1'b0, 1, 35, 0, 0, 1'b0, "R3 floor R7 blanked trip");
      drive_period(10, 1'b0, 0, 280, 0, 0, 1'b0, "R10 early trip");
      drive_period(30, 1'b0, 2, 36, 1, 1, 1'b0, "R2 upper R10 late");
      drive_period(2, 1'b0, 0, 280, 0, 0, 1'b0, "R8 minimum on");
      drive_period(-1, 1'b0, 0, 60, 0, 0, 1'b0, "R2 exact upper");
      stop = 1'b1;
      chk("R3 all periods seen", q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      nchk++;
      nfail++;
      $display("FAIL R3 watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule